// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches up to 32 GPIO inputs, which are already synchronized to its clock, and raises a sticky flag per pin when that pin shows the event it is configured for. Each pin takes five configuration bits from a bank outside this block: an interrupt-select bit, a mask bit, a trigger-type bit, a polarity bit and a both-edges bit. A pin set to level trigger flags while its active level is present. A pin set to edge trigger flags on the rising or the falling transition. When its both-edges bit is set, it flags on either transition.

Software reads the flags through a read-only flag offset. It clears flags by writing ones to a separate clear offset. The block combines the flags that are enabled and unmasked into one registered interrupt request. Software is expected to clear a pin's flag before it unmasks that pin. The mask only gates the request; it never stops a flag from being recorded.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the flag register reads zero and `irq_o` is 0.
- R2: A pin whose `cfg_sel_i` bit is 0 never sets its flag, whatever its input does.
- R3: With `cfg_edge_i`=0 (level trigger), a selected pin sets its flag at the clock edge where its input is at the active level. The active level is high when `cfg_pol_i`=1 and low when `cfg_pol_i`=0.
- R4: With `cfg_edge_i`=1 and `cfg_dual_i`=0, a selected pin sets its flag at the clock edge where the input differs from its value in the previous cycle. The transition must be 0 to 1 when `cfg_pol_i`=1, or 1 to 0 when `cfg_pol_i`=0. The opposite transition sets nothing.
- R5: With `cfg_edge_i`=1 and `cfg_dual_i`=1, both transitions set the flag and polarity is ignored. With `cfg_edge_i`=0, `cfg_dual_i` has no effect.
- R6: `rd_data_o` returns the flags when `rd_addr_i` is 0x50 and zero for any other offset.
- R7: A write with `wr_addr_i`=0x58 clears exactly the flag bits whose `wr_data_i` bits are 1. A write to any other offset leaves the flags unchanged. A set flag otherwise stays set.
- R8: When a clear and a new event hit the same bit in the same cycle, the flag stays set. A level pin whose active level is still present therefore cannot be cleared.
- R9: `irq_o` is 1 exactly one cycle after any bit of (flag AND NOT mask AND select) is 1. The mask never prevents a flag from being set.
- R10: No edge is detected at the first clock edge after reset is released. An input that is already high then produces no rising-edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | N | Synchronized pin levels |
| cfg_sel_i | input | N | Per-pin interrupt select |
| cfg_mask_i | input | N | Per-pin mask, 1 blocks the request |
| cfg_edge_i | input | N | Trigger type, 1 edge, 0 level |
| cfg_pol_i | input | N | Polarity, 1 rising/high, 0 falling/low |
| cfg_dual_i | input | N | Both-edges enable for edge pins |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | AW | Write offset |
| wr_data_i | input | N | Write data, ones select bits to clear |
| rd_addr_i | input | AW | Read offset |
| rd_data_o | output | N | Read data, flags at the flag offset |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear and an event landing on the same bit in the same cycle. Another is a pin that is already high when reset is released. The bench holds level pins at their active level while it writes the clear. This forces the collision on every such bit. It also drives the pins high throughout reset, so the first cycle after release could report a false rising edge. Each table vector first settles the pins and clears all flags. It then applies one transition, so every flag it observes comes from that single transition.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N        = 32,
  parameter int AW       = 8,
  parameter int FLAG_OFS = 'h50,
  parameter int CLR_OFS  = 'h58
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pin_i,
  input  logic [N-1:0]  cfg_sel_i,
  input  logic [N-1:0]  cfg_mask_i,
  input  logic [N-1:0]  cfg_edge_i,
  input  logic [N-1:0]  cfg_pol_i,
  input  logic [N-1:0]  cfg_dual_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [N-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [N-1:0]  rd_data_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] FLAG_A = AW'(FLAG_OFS);
  localparam logic [AW-1:0] CLR_A  = AW'(CLR_OFS);

  logic [N-1:0] prev_q, flag_q;
  logic         armed_q, irq_q;

  wire [N-1:0] rise     = pin_i & ~prev_q & {N{armed_q}};
  wire [N-1:0] fall     = ~pin_i & prev_q & {N{armed_q}};
  wire [N-1:0] edge_hit = (cfg_dual_i & (rise | fall))
                        | (~cfg_dual_i & cfg_pol_i & rise)
                        | (~cfg_dual_i & ~cfg_pol_i & fall);
  wire [N-1:0] lvl_hit  = (cfg_pol_i & pin_i) | (~cfg_pol_i & ~pin_i);
  wire [N-1:0] hit      = cfg_sel_i & ((cfg_edge_i & edge_hit) | (~cfg_edge_i & lvl_hit));
  wire [N-1:0] clr      = (wr_en_i && wr_addr_i == CLR_A) ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flag_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= pin_i;
      armed_q <= 1'b1;
      flag_q  <= (flag_q & ~clr) | hit;
      irq_q   <= |(flag_q & ~cfg_mask_i & cfg_sel_i);
    end
  end

  assign rd_data_o = (rd_addr_i == FLAG_A) ? flag_q : '0;
  assign irq_o     = irq_q;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int N       = 32,
  parameter int AW      = 8,
  parameter int CLR_OFS = 'h58
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pin_i,
  input logic [N-1:0]  cfg_sel_i,
  input logic [N-1:0]  cfg_mask_i,
  input logic [N-1:0]  cfg_edge_i,
  input logic [N-1:0]  cfg_pol_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [N-1:0]  flag_q,
  input logic          irq_o
);
  wire clr_wr = wr_en_i && (wr_addr_i == AW'(CLR_OFS));

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (flag_q == '0 && !irq_o)); // R1
  AST_NO_SEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(cfg_sel_i)) == '0)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R7
  AST_EVENT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flag_q & $past(cfg_sel_i & ~cfg_edge_i & cfg_pol_i & pin_i)) == '0)); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(flag_q & ~cfg_mask_i & cfg_sel_i)))); // R9
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N(N), .AW(AW), .CLR_OFS(CLR_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_sel_i(cfg_sel_i),
  .cfg_mask_i(cfg_mask_i), .cfg_edge_i(cfg_edge_i), .cfg_pol_i(cfg_pol_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .flag_q(flag_q), .irq_o(irq_o)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int AW = 8;

  // {prev pins, new pins, expected flags} for bits 7:0
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'hFF, 8'hD7},
    {8'hFF, 8'h00, 8'hDB},
    {8'h00, 8'h00, 8'h02},
    {8'hFF, 8'hFF, 8'hC1},
    {8'h14, 8'h08, 8'h12},
    {8'h08, 8'h24, 8'h0E}
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_i = '0, cfg_sel_i, cfg_mask_i, cfg_edge_i, cfg_pol_i, cfg_dual_i;
  logic wr_en_i = 0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = 8'h50;
  logic [N-1:0] wr_data_i = '0, rd_data_o;
  logic irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect u0 (.*);

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // bit0 lvl high, bit1 lvl low, bit2 rise, bit3 fall, bit4 dual,
  // bit5 unselected, bit6 lvl high masked, bit7 lvl high with dual set
  initial begin
    cfg_sel_i = 32'hDF; cfg_edge_i = 32'h1C; cfg_pol_i = 32'hE5;
    cfg_dual_i = 32'h90; cfg_mask_i = 32'h40;
    pin_i = 32'hFF;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", rd_data_o, '0);
    chk("R1 irq in reset", {31'b0, irq_o}, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 no edge after reset", rd_data_o, 32'hC1);
    @(negedge clk);
    chk("R10 stable input", rd_data_o, 32'hC1);

    foreach (VEC[i]) begin
      pin_i = {24'b0, VEC[i][23:16]};
      @(negedge clk);
      wr(8'h58, '1);
      pin_i = {24'b0, VEC[i][15:8]};
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), rd_data_o, {24'b0, VEC[i][7:0]});
    end

    pin_i = 32'h00; @(negedge clk);
    wr(8'h58, '1);
    pin_i = 32'hFF; @(negedge clk);
    chk("R4 setup", rd_data_o, 32'hD7);
    wr(8'h54, '1);
    chk("R7 write elsewhere ignored", rd_data_o, 32'hD7);
    rd_addr_i = 8'h54;
    #1 chk("R6 other offset reads zero", rd_data_o, '0);
    rd_addr_i = 8'h50;
    wr(8'h58, 32'h14);
    chk("R7 selective clear", rd_data_o, 32'hC3);
    wr(8'h58, 32'h01);
    chk("R8 event beats clear", rd_data_o, 32'hC3);

    cfg_mask_i = '1;
    @(negedge clk);
    chk("R9 masked irq", {31'b0, irq_o}, 32'd0);
    chk("R9 flags kept under mask", rd_data_o, 32'hC3);
    cfg_mask_i = 32'h40;
    @(negedge clk);
    chk("R9 unmasked irq", {31'b0, irq_o}, 32'd1);

    pin_i = 32'h02; @(negedge clk);
    chk("R4 fall and dual", rd_data_o, 32'hDB);
    wr(8'h58, '1);
    chk("R7 clear all", rd_data_o, '0);
    chk("R9 irq lags flags", {31'b0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq_o}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule